// File: doc/BRIEF.md
# Lockable Watchdog Timer with Commit Tracking

This block is a memory-mapped watchdog. A free-running down-counter runs from a programmable reload value while the watchdog is enabled. When the counter reaches zero, the block raises a one-cycle reset request and starts the count again from the reload value. Software prevents expiry by writing anything to a kick register, which puts the reload value back into the counter.

Writes to the reload and enable registers are not applied at once. Each one is held in a commit stage for a fixed number of cycles, set by a parameter. While a commit is pending, a status word shows which register is still being written. A second reload or enable write that arrives during that window is discarded and sets a sticky error flag. Software clears the flag by writing a one to it.

A key register guards every other writable register. Only one exact key value opens the block, and any other value closes it. While the block is closed, writes to the guarded registers are dropped without any sign. The bus is a plain single-cycle interface: address, write strobe, write data and read data. Read data is registered and appears one cycle after the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the key register reads 0 (open), the enable bit reads 0, the reload register and the counter both read 0xFFFFFFFF, the status word reads 0 and rst_req is low.
- R2: The block returns read data on the clock edge after the address is presented, using the state just before that edge. The offsets are: 0x00 reload, 0x04 counter (read-only), 0x08 enable (bit 0 only), 0x0C kick (reads 0), 0x10 key register (bit 0 only), 0x14 status. Any other offset reads 0.
- R3: While enabled, the counter falls by exactly one each cycle. While disabled, it holds its value.
- R4: An enabled counter that is at zero on a clock edge reloads from the reload register on that edge, and rst_req is high for exactly that one cycle.
- R5: An accepted write to reload or enable takes COMMIT_LAT cycles (4 by default) to apply. During that time status bit 0 is set, together with bit 1 (reload) or bit 2 (enable). A committed reload value also restarts the counter from that value.
- R6: A write to reload or enable that arrives while either one is busy is discarded and sets status bit 3.
- R7: Writing status with bit 3 set clears the error flag. Writing status with bit 3 clear has no effect. Status bits 0 to 2 ignore writes.
- R8: A write of any data to the kick offset loads the committed reload value into the counter.
- R9: Writing exactly 0x1ACCE551 to the key register opens the block (reads 0). Any other value closes it (reads 1). Writes to the key register are always accepted.
- R10: While the block is closed, writes to reload, enable, kick and status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bound checker checks these properties on every cycle:
- The counter falls by one, or holds, whenever no kick or commit intervenes.
- Expiry always produces a single-cycle rst_req.
- A reload write is accepted when the block is open and idle, and refused when it is closed.
- A write during a busy window always sets the error flag.
- The key register always follows the key comparison.
- At most one busy bit is set at a time.

Some behaviour shows only in the bench's scenarios. These are:
- The exact length of the busy window.
- The moment a new reload value takes effect.
- Error clearing through the status write.
- A closed block ignoring kicks and status writes.
- The read data values at each offset.

The bench drives these through directed sequences and a random register-traffic mix. It compares against a cycle-level reference model on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register byte offsets; software decodes these, so they are fixed.
  localparam int OFS_LOAD   = 'h00;
  localparam int OFS_VALUE  = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_KICK   = 'h0C;
  localparam int OFS_LOCK   = 'h10;
  localparam int OFS_STATUS = 'h14;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  // Status word bit positions
  localparam int ST_BUSY_ANY  = 0;
  localparam int ST_BUSY_LOAD = 1;
  localparam int ST_BUSY_CTRL = 2;
  localparam int ST_WR_ERR    = 3;
  localparam int ST_BITS      = 4;

  // Commit slots
  localparam int SLOT_LOAD = 0;
  localparam int SLOT_CTRL = 1;
  localparam int NUM_SLOTS = 2;

  typedef struct packed {
    logic load;
    logic ctrl;
    logic kick;
    logic lock;
    logic status;
  } wr_strobe_t;

endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output wr_strobe_t        strobe,
  output logic              locked
);

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [DATA_W-1:0] KEY      = DATA_W'(UNLOCK_KEY);

  logic locked_q;

  // Key register: always writable, opens only on the exact key.
  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
    end else if (we && addr == A_LOCK) begin
      locked_q <= (wdata != KEY);
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.lock = we && (addr == A_LOCK);
    if (we && !locked_q) begin
      strobe.load   = (addr == A_LOAD);
      strobe.ctrl   = (addr == A_CTRL);
      strobe.kick   = (addr == A_KICK);
      strobe.status = (addr == A_STATUS);
    end
  end

  assign locked = locked_q;

endmodule

// File: rtl/wdog_commit.sv
module wdog_commit #(
  parameter int DATA_W     = 32,
  parameter int LATENCY    = 4,
  parameter int NSLOT      = 2,
  parameter int ERR_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSLOT-1:0]  req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_wr,
  output logic [NSLOT-1:0]  busy,
  output logic [NSLOT-1:0]  commit,
  output logic [DATA_W-1:0] commit_data,
  output logic              err
);

  localparam int LAT_W = $clog2(LATENCY + 1);
  localparam logic [LAT_W-1:0] LAT_INIT = LAT_W'(LATENCY);
  localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);

  logic [LAT_W-1:0]  lat_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;
  logic              busy_any;
  logic              req_any;
  logic              last;

  assign busy_any = |busy;
  assign req_any  = |req;
  assign last     = (lat_q == LAT_ONE);

  // One busy flag per committed register
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic slot_busy_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_busy_q <= 1'b0;
      end else if (busy_any) begin
        if (last) slot_busy_q <= 1'b0;
      end else if (req_any) begin
        slot_busy_q <= req[i];
      end
    end
    assign busy[i]   = slot_busy_q;
    assign commit[i] = slot_busy_q & last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (busy_any) begin
        lat_q <= lat_q - LAT_ONE;
      end else if (req_any) begin
        lat_q  <= LAT_INIT;
        data_q <= wdata;
      end
      if (req_any && busy_any) begin
        err_q <= 1'b1;
      end else if (err_wr && wdata[ERR_BIT]) begin
        err_q <= 1'b0;
      end
    end
  end

  assign commit_data = data_q;
  assign err         = err_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] LOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_load,
  input  logic              commit_ctrl,
  input  logic [DATA_W-1:0] commit_data,
  input  logic              kick,
  output logic [DATA_W-1:0] load_val,
  output logic              enabled,
  output logic [DATA_W-1:0] count,
  output logic              expire
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  logic              en_q;
  logic              exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= LOAD_INIT;
      cnt_q  <= LOAD_INIT;
      en_q   <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (commit_ctrl) en_q <= commit_data[0];
      if (commit_load) begin
        load_q <= commit_data;
        cnt_q  <= commit_data;
      end else if (kick) begin
        cnt_q <= load_q;
      end else if (en_q) begin
        if (cnt_q == '0) begin
          exp_q <= 1'b1;
          cnt_q <= load_q;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign load_val = load_q;
  assign enabled  = en_q;
  assign count    = cnt_q;
  assign expire   = exp_q;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int COMMIT_LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

  wr_strobe_t            strobe;
  logic                  locked;
  logic [NUM_SLOTS-1:0]  req;
  logic [NUM_SLOTS-1:0]  busy;
  logic [NUM_SLOTS-1:0]  commit;
  logic [DATA_W-1:0]     commit_data;
  logic                  wr_err;
  logic [DATA_W-1:0]     load_val;
  logic                  enabled;
  logic [DATA_W-1:0]     count;
  logic                  expire;
  logic [DATA_W-1:0]     rdata_q;
  logic [DATA_W-1:0]     rd_mux;
  logic [ST_BITS-1:0]    status_w;

  wdog_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk    (clk),
    .rst    (rst),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .strobe (strobe),
    .locked (locked)
  );

  assign req[SLOT_LOAD] = strobe.load;
  assign req[SLOT_CTRL] = strobe.ctrl;

  wdog_commit #(
    .DATA_W  (DATA_W),
    .LATENCY (COMMIT_LAT),
    .NSLOT   (NUM_SLOTS),
    .ERR_BIT (ST_WR_ERR)
  ) u_commit (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .wdata       (bus_wdata),
    .err_wr      (strobe.status),
    .busy        (busy),
    .commit      (commit),
    .commit_data (commit_data),
    .err         (wr_err)
  );

  wdog_counter #(.DATA_W(DATA_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .commit_load (commit[SLOT_LOAD]),
    .commit_ctrl (commit[SLOT_CTRL]),
    .commit_data (commit_data),
    .kick        (strobe.kick),
    .load_val    (load_val),
    .enabled     (enabled),
    .count       (count),
    .expire      (expire)
  );

  always_comb begin
    status_w = '0;
    status_w[ST_BUSY_ANY]  = |busy;
    status_w[ST_BUSY_LOAD] = busy[SLOT_LOAD];
    status_w[ST_BUSY_CTRL] = busy[SLOT_CTRL];
    status_w[ST_WR_ERR]    = wr_err;
  end

  always_comb begin
    case (bus_addr)
      A_LOAD:   rd_mux = load_val;
      A_VALUE:  rd_mux = count;
      A_CTRL:   rd_mux = DATA_W'(enabled);
      A_LOCK:   rd_mux = DATA_W'(locked);
      A_STATUS: rd_mux = DATA_W'(status_w);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign rst_req   = expire;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 locked,
  input logic [NUM_SLOTS-1:0] busy,
  input logic [NUM_SLOTS-1:0] commit,
  input logic                 wr_err,
  input logic                 enabled,
  input logic [DATA_W-1:0]    count,
  input logic                 rst_req
);

  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
  localparam logic [DATA_W-1:0] KEY    = DATA_W'(UNLOCK_KEY);

  logic kick_w;
  logic cfg_w;
  assign kick_w = bus_we && !locked && bus_addr == A_KICK;
  assign cfg_w  = bus_we && !locked && (bus_addr == A_LOAD || bus_addr == A_CTRL);

  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    enabled && count != '0 && !(|commit) && !kick_w |=> count == $past(count) - DATA_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !enabled && !(|commit) && !kick_w |=> $stable(count));

  a_r4_expire: assert property (@(posedge clk) disable iff (rst)
    enabled && count == '0 && !(|commit) && !kick_w |=> rst_req);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req && count != '0 |=> !rst_req);

  a_r5_load_accept: assert property (@(posedge clk) disable iff (rst)
    bus_we && !locked && bus_addr == A_LOAD && !(|busy) |=> busy[SLOT_LOAD] && !busy[SLOT_CTRL]);

  a_r6_one_busy: assert property (@(posedge clk) disable iff (rst) $onehot0(busy));

  a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
    cfg_w && (|busy) |=> wr_err);

  a_r9_key_compare: assert property (@(posedge clk) disable iff (rst)
    bus_we && bus_addr == A_LOCK |=> locked == ($past(bus_wdata) != KEY));

  a_r10_locked_load: assert property (@(posedge clk) disable iff (rst)
    bus_we && locked && bus_addr == A_LOAD && !(|busy) |=> !(|busy));

endmodule

bind wdog_timer wdog_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .locked    (locked),
  .busy      (busy),
  .commit    (commit),
  .wr_err    (wr_err),
  .enabled   (enabled),
  .count     (count),
  .rst_req   (rst_req)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;

  localparam int LAT = 4;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_tag = "R1 reset";

  always #2.5 clk = ~clk;

  wdog_timer #(.ADDR_W(8), .DATA_W(32), .COMMIT_LAT(LAT)) u_wdog_timer (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .rst_req (rst_req)
  );

  // Reference model state
  logic [31:0] m_load, m_cnt, m_pend, m_rdata;
  logic        m_en, m_locked, m_bl, m_bc, m_err, m_rst;
  int          m_lat;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_load;
      8'h04:   return m_cnt;
      8'h08:   return {31'd0, m_en};
      8'h10:   return {31'd0, m_locked};
      8'h14:   return {28'd0, m_err, m_bc, m_bl, m_bl | m_bc};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_load = '1; m_cnt = '1; m_pend = '0; m_rdata = '0;
    m_en = 0; m_locked = 0; m_bl = 0; m_bc = 0; m_err = 0; m_rst = 0; m_lat = 0;
  endtask

  task automatic model_step();
    logic open, req_l, req_c, kick, clr, busy_old, cm_l, cm_c, en_old;
    logic [31:0] pend_old;
    m_rdata  = model_read(bus_addr);
    open     = !m_locked;
    req_l    = bus_we && open && bus_addr == 8'h00;
    req_c    = bus_we && open && bus_addr == 8'h08;
    kick     = bus_we && open && bus_addr == 8'h0C;
    clr      = bus_we && open && bus_addr == 8'h14 && bus_wdata[3];
    busy_old = m_bl | m_bc;
    cm_l     = m_bl && m_lat == 1;
    cm_c     = m_bc && m_lat == 1;
    pend_old = m_pend;
    en_old   = m_en;
    if (bus_we && bus_addr == 8'h10) m_locked = (bus_wdata != KEY);
    if (busy_old) begin
      if (m_lat == 1) begin m_bl = 0; m_bc = 0; end
      m_lat--;
    end else if (req_l || req_c) begin
      m_bl = req_l; m_bc = req_c; m_lat = LAT; m_pend = bus_wdata;
    end
    if ((req_l || req_c) && busy_old) m_err = 1;
    else if (clr) m_err = 0;
    m_rst = 0;
    if (cm_c) m_en = pend_old[0];
    if (cm_l) begin m_load = pend_old; m_cnt = pend_old; end
    else if (kick) m_cnt = m_load;
    else if (en_old) begin
      if (m_cnt == 0) begin m_rst = 1; m_cnt = m_load; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d);
    bus_addr = a; bus_we = w; bus_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk({cur_tag, " rdata"}, bus_rdata, m_rdata);
    chk({cur_tag, " rst_req"}, {31'd0, rst_req}, {31'd0, m_rst});
  endtask

  task automatic rd(input logic [7:0] a); cyc(a, 1'b0, 32'd0); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); cyc(a, 1'b1, d); endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rst_req after reset", {31'd0, rst_req}, 32'd0);

    // R1 reset values
    cur_tag = "R1 reset";
    rd(8'h00); chk("R1 reload", bus_rdata, 32'hFFFF_FFFF);
    rd(8'h04); chk("R1 counter", bus_rdata, 32'hFFFF_FFFF);
    rd(8'h08); chk("R1 enable", bus_rdata, 32'd0);
    rd(8'h10); chk("R1 key reg", bus_rdata, 32'd0);
    rd(8'h14); chk("R1 status", bus_rdata, 32'd0);
    cur_tag = "R2 offsets";
    rd(8'h0C); chk("R2 kick reads zero", bus_rdata, 32'd0);
    rd(8'h18); chk("R2 unmapped reads zero", bus_rdata, 32'd0);

    // R5 commit latency
    cur_tag = "R5 commit";
    wr(8'h00, 32'd10);
    rd(8'h14); chk("R5 busy reload", bus_rdata, 32'h3);
    rd(8'h00); chk("R5 old reload while busy", bus_rdata, 32'hFFFF_FFFF);
    rd(8'h14); rd(8'h14); chk("R5 still busy at last cycle", bus_rdata, 32'h3);
    rd(8'h14); chk("R5 busy clear", bus_rdata, 32'h0);
    rd(8'h00); chk("R5 reload committed", bus_rdata, 32'd10);
    rd(8'h04); chk("R5 counter restarted", bus_rdata, 32'd10);

    // R6 write during busy
    cur_tag = "R6 busy error";
    wr(8'h08, 32'd1);
    wr(8'h00, 32'd5);
    repeat (LAT) rd(8'h14);
    rd(8'h14); chk("R6 error sticky", bus_rdata, 32'h8);
    rd(8'h00); chk("R6 dropped reload", bus_rdata, 32'd10);
    rd(8'h08); chk("R6 enable committed", bus_rdata, 32'd1);

    // R7 error clear
    cur_tag = "R7 error clear";
    wr(8'h14, 32'h7); rd(8'h14); chk("R7 bit3 clear write ignored", bus_rdata, 32'h8);
    wr(8'h14, 32'h8); rd(8'h14); chk("R7 error cleared", bus_rdata, 32'h0);

    // R8 / R4 kick and expiry
    cur_tag = "R8 kick";
    wr(8'h0C, 32'hDEAD_BEEF);
    cur_tag = "R3 countdown";
    for (int i = 0; i < 10; i++) begin
      rd(8'h14);
      chk("R4 no early expiry", {31'd0, rst_req}, 32'd0);
    end
    rd(8'h14); chk("R4 expiry pulse", {31'd0, rst_req}, 32'd1);
    rd(8'h04); chk("R4 reloaded after expiry", bus_rdata, 32'd10);
    chk("R4 pulse single cycle", {31'd0, rst_req}, 32'd0);

    // R9 / R10 locking
    cur_tag = "R9 key";
    wr(8'h10, KEY ^ 32'h1);
    rd(8'h10); chk("R9 near-key closes", bus_rdata, 32'd1);
    cur_tag = "R10 closed";
    wr(8'h00, 32'd3);
    rd(8'h14); chk("R10 reload ignored busy", bus_rdata, 32'd0);
    rd(8'h00); chk("R10 reload ignored value", bus_rdata, 32'd10);
    wr(8'h08, 32'd0);
    rd(8'h14); rd(8'h08); chk("R10 enable ignored", bus_rdata, 32'd1);
    wr(8'h0C, 32'd0);
    rd(8'h04);
    wr(8'h10, KEY);
    rd(8'h10); chk("R9 key opens", bus_rdata, 32'd0);
    wr(8'h10, 32'd0);
    rd(8'h10); chk("R9 zero closes", bus_rdata, 32'd1);
    wr(8'h10, KEY);

    // Random traffic
    cur_tag = "R2/R3/R4 random";
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      sel = $urandom_range(0, 99);
      if (sel < 55)      rd(8'($urandom_range(0, 6) * 4));
      else if (sel < 65) wr(8'h00, $urandom_range(1, 40));
      else if (sel < 72) wr(8'h08, $urandom_range(0, 3));
      else if (sel < 80) wr(8'h0C, $urandom());
      else if (sel < 86) wr(8'h14, $urandom_range(0, 15));
      else if (sel < 93) wr(8'h10, KEY);
      else if (sel < 96) wr(8'h10, $urandom());
      else               wr(8'h04, $urandom());
    end

    summary();
    $finish;
  end

endmodule